// File: doc/BRIEF.md
# Line Code Violation Monitor

This block watches the receive side of a T1 or E1 line as a stream of bipolar symbols. Each symbol arrives on two rails, one for positive marks and one for negative marks, and is qualified by a valid strobe that pulses once per recovered bit. The monitor reports three kinds of fault, each as a one-cycle strobe.

- **Bipolar violation:** two successive marks of the same polarity. Violations that belong to a zero-substitution code word are not reported. Those code words are the 8-zero replacement used on T1 lines and the 4-zero replacement used on E1 lines, and a mode pin chooses between them.
- **Excessive zeros:** a run of zeros after a mark that reaches a length of 8 or 16, chosen by a pin.
- **Line code violation:** a single strobe that merges the two faults above and is meant to drive an error counter. An enable pin decides whether excessive-zeros events are added to it.

The symbol input has a valid qualifier but no ready. A line cannot be paused, so the block accepts every valid symbol in the cycle it is presented and never applies back-pressure. When valid is low, no state advances.

A violation can only be excused after the rest of its code word has been seen. For this reason the bipolar violation report for a symbol is held back until four more symbols have been accepted, in both modes. Excessive-zeros detection is not delayed.

Top module: `lcv_monitor`

## Requirements
- R1: While reset is asserted and on release, `bpv_stb`, `exz_stb` and `lcv_stb` are all low.
- R2: Symbol encoding on the rails `{rail_p, rail_n}` is as follows: `10` is a positive mark, `01` is a negative mark, `00` is a zero and `11` is an invalid symbol. A mark with the same polarity as the previous mark is a violation. When a violation is not excused, `bpv_stb` is high for one cycle, starting with the cycle after the edge that accepts the fourth valid symbol following the violating one. Marks that alternate in polarity never raise it.
- R3: The first mark after reset has no earlier mark to compare with, so it is never a violation.
- R4: An invalid symbol is always reported as a violation and is never excused. It leaves the stored polarity of the last mark unchanged, and it ends a zero run.
- R5: With `cfg_hdb3`=0, consider the 8-symbol word zero, zero, zero, V, B, zero, V, B. Here each V is a violating mark and each B is a non-violating mark. Neither V in that word is reported. A violation in a partial word is reported.
- R6: With `cfg_hdb3`=1, a violating mark is not reported if it follows three zeros, or a non-violating mark and then two zeros. Any other violation is reported.
- R7: After a mark, the zero run is counted. `exz_stb` pulses once, on the zero that brings the run to 8 (`cfg_exz16`=0) or to 16 (`cfg_exz16`=1). The pulse starts in the cycle after that zero is accepted. It does not pulse again until a mark or an invalid symbol starts a new run.
- R8: Zeros accepted before the first mark or invalid symbol after reset are not counted, so they never raise `exz_stb`.
- R9: `lcv_stb` is high when `bpv_stb` is high, or when `exz_stb` is high and `cfg_exz_lcv_en` was 1 at the accepting edge. When `cfg_exz_lcv_en` is 0, an excessive-zeros event leaves `lcv_stb` low.
- R10: When `sym_vld` is low, the symbol is ignored and all strobes are low in the following cycle. A code word split by idle cycles is still recognised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_vld | input | 1 | Qualifies one received symbol on the rails |
| rail_p | input | 1 | Positive mark rail |
| rail_n | input | 1 | Negative mark rail |
| cfg_hdb3 | input | 1 | 0 selects the 8-zero T1 substitution, 1 selects the 4-zero E1 substitution |
| cfg_exz16 | input | 1 | 0 sets the zero-run threshold to 8, 1 sets it to 16 |
| cfg_exz_lcv_en | input | 1 | Adds excessive-zeros events to `lcv_stb` |
| bpv_stb | output | 1 | Unexcused bipolar violation or invalid symbol |
| exz_stb | output | 1 | Zero run reached the threshold |
| lcv_stb | output | 1 | Combined strobe for the error counter |

## Verification
The bench builds the block with its default thresholds of 8 and 16. Both thresholds can therefore be reached in a few dozen symbols, which keeps the following within a short run:

- the single pulse and the lack of a repeat pulse;
- the unarmed start after reset;
- the switch between the two thresholds.

The substitution window is fixed by the line codes. This lets the bench complete and break both code words, and stretch one with idle gaps, all at the same report depth of four symbols.

// File: rtl/lcvm_pkg.sv
package lcvm_pkg;

  // Class of one accepted symbol as seen by the exclusion window.
  typedef enum logic [2:0] {
    SYM_NONE = 3'd0,  // window slot not yet filled since reset
    SYM_ZERO = 3'd1,
    SYM_MARK = 3'd2,  // mark with polarity opposite to the previous mark
    SYM_VIOL = 3'd3,  // mark with the same polarity as the previous mark
    SYM_BAD  = 3'd4   // both rails asserted
  } sym_class_e;

  // Longest substitution word (T1 eight-zero replacement).
  localparam int unsigned WIN_SPAN   = 8;
  // Window age at which a symbol is finally judged; the T1 word has
  // four symbols after its first violation.
  localparam int unsigned REPORT_AGE = 4;

endpackage

// File: rtl/lcvm_classify.sv
module lcvm_classify
  import lcvm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vld,
  input  logic       p,
  input  logic       n,
  output sym_class_e cls
);

  logic seen_mark;
  logic last_pos;

  always_comb begin
    if (p && n)
      cls = SYM_BAD;
    else if (p || n)
      cls = (seen_mark && (last_pos == p)) ? SYM_VIOL : SYM_MARK;
    else
      cls = SYM_ZERO;
  end

  // Only a well-formed mark updates the polarity reference.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_mark <= 1'b0;
      last_pos  <= 1'b0;
    end else if (vld && (p ^ n)) begin
      seen_mark <= 1'b1;
      last_pos  <= p;
    end
  end

endmodule

// File: rtl/lcvm_zero_run.sv
module lcvm_zero_run
  import lcvm_pkg::*;
#(
  parameter int unsigned EXZ_SHORT = 8,
  parameter int unsigned EXZ_LONG  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vld,
  input  sym_class_e cls,
  input  logic       long_sel,
  output logic       hit
);

  localparam int unsigned CNT_W = $clog2(EXZ_LONG + 1);

  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W-1:0] thr;
  logic             inc;
  logic             restart;

  assign thr     = long_sel ? CNT_W'(EXZ_LONG) : CNT_W'(EXZ_SHORT);
  assign restart = vld && (cls != SYM_ZERO) && (cls != SYM_NONE);
  // Count saturates at the long threshold, so no second pulse per run.
  assign inc     = vld && armed && (cls == SYM_ZERO) && (cnt < CNT_W'(EXZ_LONG));
  assign cnt_nx  = cnt + CNT_W'(1);
  assign hit     = inc && (cnt_nx == thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (restart) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (inc) begin
      cnt   <= cnt_nx;
    end
  end

endmodule

// File: rtl/lcvm_sub_window.sv
module lcvm_sub_window
  import lcvm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vld,
  input  sym_class_e cls,
  input  logic       hdb3,
  output logic       hit
);

  sym_class_e          win  [WIN_SPAN];
  sym_class_e          nwin [WIN_SPAN];
  logic [WIN_SPAN-1:0] exc;
  logic [WIN_SPAN-1:0] nexc;
  logic                t1_word;
  logic                e1_word;

  // Window as it will be after this symbol is shifted in (age 0 newest).
  assign nwin[0] = cls;
  generate
    for (genvar g = 1; g < WIN_SPAN; g++) begin : g_shift
      assign nwin[g] = win[g-1];
    end
  endgenerate

  // T1: oldest..newest = 0 0 0 V B 0 V B
  assign t1_word = (nwin[7] == SYM_ZERO) && (nwin[6] == SYM_ZERO) &&
                   (nwin[5] == SYM_ZERO) && (nwin[4] == SYM_VIOL) &&
                   (nwin[3] == SYM_MARK) && (nwin[2] == SYM_ZERO) &&
                   (nwin[1] == SYM_VIOL) && (nwin[0] == SYM_MARK);

  // E1: 0 0 0 V  or  B 0 0 V
  assign e1_word = (nwin[0] == SYM_VIOL) && (nwin[1] == SYM_ZERO) &&
                   (nwin[2] == SYM_ZERO) &&
                   ((nwin[3] == SYM_ZERO) || (nwin[3] == SYM_MARK));

  always_comb begin
    nexc = {exc[WIN_SPAN-2:0], 1'b0};
    if (!hdb3 && t1_word) begin
      nexc[REPORT_AGE] = 1'b1;
      nexc[1]          = 1'b1;
    end
    if (hdb3 && e1_word)
      nexc[0] = 1'b1;
  end

  assign hit = vld &&
               ((nwin[REPORT_AGE] == SYM_VIOL) || (nwin[REPORT_AGE] == SYM_BAD)) &&
               !nexc[REPORT_AGE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN_SPAN; i++) win[i] <= SYM_NONE;
      exc <= '0;
    end else if (vld) begin
      for (int i = 0; i < WIN_SPAN; i++) win[i] <= nwin[i];
      exc <= nexc;
    end
  end

endmodule

// File: rtl/lcv_monitor.sv
module lcv_monitor
  import lcvm_pkg::*;
#(
  parameter int unsigned EXZ_SHORT = 8,
  parameter int unsigned EXZ_LONG  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sym_vld,
  input  logic rail_p,
  input  logic rail_n,
  input  logic cfg_hdb3,
  input  logic cfg_exz16,
  input  logic cfg_exz_lcv_en,
  output logic bpv_stb,
  output logic exz_stb,
  output logic lcv_stb
);

  sym_class_e cls;
  logic       bpv_hit;
  logic       exz_hit;

  lcvm_classify u_cls (
    .clk (clk),
    .rst_n (rst_n),
    .vld (sym_vld),
    .p (rail_p),
    .n (rail_n),
    .cls (cls)
  );

  lcvm_zero_run #(
    .EXZ_SHORT (EXZ_SHORT),
    .EXZ_LONG  (EXZ_LONG)
  ) u_zrun (
    .clk (clk),
    .rst_n (rst_n),
    .vld (sym_vld),
    .cls (cls),
    .long_sel (cfg_exz16),
    .hit (exz_hit)
  );

  lcvm_sub_window u_win (
    .clk (clk),
    .rst_n (rst_n),
    .vld (sym_vld),
    .cls (cls),
    .hdb3 (cfg_hdb3),
    .hit (bpv_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpv_stb <= 1'b0;
      exz_stb <= 1'b0;
      lcv_stb <= 1'b0;
    end else begin
      bpv_stb <= bpv_hit;
      exz_stb <= exz_hit;
      lcv_stb <= bpv_hit | (exz_hit & cfg_exz_lcv_en);
    end
  end

endmodule

// File: rtl/lcvm_chk.sv
module lcvm_chk (
  input logic clk,
  input logic rst_n,
  input logic sym_vld,
  input logic rail_p,
  input logic rail_n,
  input logic cfg_exz_lcv_en,
  input logic bpv_stb,
  input logic exz_stb,
  input logic lcv_stb
);

  logic line_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_active <= 1'b0;
    else if (sym_vld && (rail_p || rail_n)) line_active <= 1'b1;
  end

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sym_vld) |-> (!bpv_stb && !exz_stb && !lcv_stb));

  // R9
  lcv_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcv_stb == (bpv_stb || (exz_stb && $past(cfg_exz_lcv_en))));

  // R7
  exz_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exz_stb |=> !exz_stb);

  // R7
  exz_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exz_stb |-> $past(sym_vld && !rail_p && !rail_n));

  // R8
  exz_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exz_stb |-> line_active);

endmodule

bind lcv_monitor lcvm_chk u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .sym_vld (sym_vld),
  .rail_p (rail_p),
  .rail_n (rail_n),
  .cfg_exz_lcv_en (cfg_exz_lcv_en),
  .bpv_stb (bpv_stb),
  .exz_stb (exz_stb),
  .lcv_stb (lcv_stb)
);

// File: tb/lcv_monitor_tb.sv
module lcv_monitor_tb;

  localparam int SHORT = 8;
  localparam int LONG  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_vld = 1'b0;
  logic rail_p = 1'b0;
  logic rail_n = 1'b0;
  logic cfg_hdb3 = 1'b0;
  logic cfg_exz16 = 1'b1;
  logic cfg_exz_lcv_en = 1'b1;
  logic bpv_stb, exz_stb, lcv_stb;

  always #5 clk = ~clk;

  lcv_monitor #(.EXZ_SHORT(SHORT), .EXZ_LONG(LONG)) u_dut (
    .clk (clk), .rst_n (rst_n), .sym_vld (sym_vld),
    .rail_p (rail_p), .rail_n (rail_n),
    .cfg_hdb3 (cfg_hdb3), .cfg_exz16 (cfg_exz16),
    .cfg_exz_lcv_en (cfg_exz_lcv_en),
    .bpv_stb (bpv_stb), .exz_stb (exz_stb), .lcv_stb (lcv_stb)
  );

  typedef struct {
    bit    bpv;
    bit    exz;
    bit    lcv;
    string tag;
  } exp_t;

  exp_t q[$];
  bit   dline[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 0;

  // Reference state from the requirements
  bit m_have, m_pos, m_armed;
  int m_cnt;

  task automatic model_clear();
    m_have = 0; m_pos = 0; m_armed = 0; m_cnt = 0;
    dline.delete();
  endtask

  task automatic send(input bit p, input bit n, input bit exc, input string tag);
    exp_t e;
    bit raw, ex;
    @(negedge clk);
    sym_vld = 1; rail_p = p; rail_n = n;
    raw = 0; ex = 0;
    if (p && n) begin
      raw = 1; m_armed = 1; m_cnt = 0;
    end else if (p || n) begin
      raw = m_have && (m_pos == p);
      m_have = 1; m_pos = p; m_armed = 1; m_cnt = 0;
    end else if (m_armed && m_cnt < LONG) begin
      m_cnt++;
      ex = (m_cnt == (cfg_exz16 ? LONG : SHORT));
    end
    dline.push_back(raw && !exc);
    e.bpv = (dline.size() > 4) ? dline.pop_front() : 1'b0;
    e.exz = ex;
    e.lcv = e.bpv | (ex & cfg_exz_lcv_en);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic pos(input string tag, input bit exc = 0); send(1, 0, exc, tag); endtask
  task automatic neg(input string tag, input bit exc = 0); send(0, 1, exc, tag); endtask
  task automatic zer(input int k, input string tag);
    for (int i = 0; i < k; i++) send(0, 0, 0, tag);
  endtask

  task automatic idle(input int k, input string tag);
    exp_t e;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      sym_vld = 0; rail_p = 0; rail_n = 0;
      e.bpv = 0; e.exz = 0; e.lcv = 0; e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic do_reset(input bit hdb3, input bit long16, input bit en);
    idle(1, "R10");
    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    rst_n = 0; sym_vld = 0;
    cfg_hdb3 = hdb3; cfg_exz16 = long16; cfg_exz_lcv_en = en;
    repeat (2) @(negedge clk);
    n_chk++;
    if ({bpv_stb, exz_stb, lcv_stb} !== 3'b000) begin
      n_err++;
      $display("FAIL R1: strobes in reset actual=%b expected=000",
               {bpv_stb, exz_stb, lcv_stb});
    end
    model_clear();
    @(negedge clk);
    rst_n = 1;
  endtask

  // Monitor: one expected item per driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if ({bpv_stb, exz_stb, lcv_stb} !== {e.bpv, e.exz, e.lcv}) begin
          n_err++;
          $display("FAIL %s: bpv/exz/lcv actual=%b expected=%b at %0t",
                   e.tag, {bpv_stb, exz_stb, lcv_stb}, {e.bpv, e.exz, e.lcv}, $time);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    model_clear();
    // R1 reset state, B8ZS mode, long threshold
    do_reset(0, 1, 1);

    // R3 first mark, R2 alternation and same-polarity pairs
    pos("R3"); zer(1, "R2"); neg("R2"); pos("R2"); neg("R2");
    neg("R2"); pos("R2"); pos("R2"); neg("R2");
    zer(5, "R2");

    // R4 invalid symbol: reported, polarity kept (next + is a violation)
    do_reset(0, 1, 1);
    pos("R4"); send(1, 1, 0, "R4"); pos("R4"); neg("R4");
    zer(5, "R4");

    // R5 complete T1 word excused, partial word reported
    do_reset(0, 1, 1);
    pos("R5"); zer(3, "R5"); pos("R5", 1); neg("R5"); zer(1, "R5");
    neg("R5", 1); pos("R5"); neg("R5"); pos("R5");
    zer(3, "R5"); pos("R5"); neg("R5"); zer(2, "R5"); pos("R5");
    zer(5, "R5");

    // R10 T1 word split by idle cycles is still excused
    do_reset(0, 1, 1);
    pos("R10"); idle(2, "R10"); zer(3, "R10"); idle(1, "R10");
    pos("R10", 1); idle(3, "R10"); neg("R10"); zer(1, "R10");
    idle(1, "R10"); neg("R10", 1); pos("R10"); idle(2, "R10");
    neg("R10"); zer(5, "R10");

    // R6 E1 words 000V and B00V excused; others reported
    do_reset(1, 1, 1);
    pos("R6"); zer(3, "R6"); pos("R6", 1);
    neg("R6"); zer(2, "R6"); neg("R6", 1);
    pos("R6"); pos("R6"); zer(1, "R6"); pos("R6");
    neg("R6"); zer(5, "R6");

    // R8 zeros before any mark, then R7 short threshold, no re-fire
    do_reset(0, 0, 1);
    zer(20, "R8");
    pos("R7"); zer(12, "R7");
    neg("R7"); zer(7, "R7"); pos("R7"); zer(9, "R7");

    // R7 long threshold
    do_reset(0, 1, 1);
    neg("R7"); zer(18, "R7"); pos("R7"); zer(16, "R7");

    // R9 excessive zeros kept out of lcv, bpv still merged
    do_reset(0, 0, 0);
    pos("R9"); zer(10, "R9"); pos("R9"); pos("R9"); neg("R9");
    zer(9, "R9");

    idle(3, "R10");
    while (q.size() > 0) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule